// File: doc/BRIEF.md
# Offset Calibration Accumulator

This engine measures the DC offset present on a voltage input and a current input and stores it in one offset register per channel. A run starts with a pulse on `start` that carries a pair of channel selects. For a programmable number of clock cycles every flagged sample of both inputs is added to its own signed accumulator, and the engine counts how many samples it took. After the interval a single shared sequential divider turns each selected sum into a mean. The mean is written to the offset register of that channel.

When the run ends, the engine forces both high-pass filter coefficient registers to zero, so that the filter no longer pulls the offsets away from their calibrated values. It then gives a single-cycle completion pulse. The coefficient registers can be written from outside while the engine is idle. The sample source and the filter datapath sit outside this block.

Top module: `offset_cal_engine`

## Requirements
- R1: Reset leaves both offset registers and both filter coefficients at zero, with `busy`, `done`, `failV` and `failI` low.
- R2: A `start` pulse while idle latches `selV` and `selI` and opens an interval of exactly `calCycles` clock cycles, beginning with the cycle after the pulse. In each of these cycles where `sampleValid` is high, both samples are added to their channel sums.
- R3: Each mean is the signed channel sum divided by the number of samples taken, truncated toward zero. The two's-complement result is `SAMPLE_W` bits wide.
- R4: A mean is written only to the offset register of a selected channel. The offset of an unselected channel keeps its value, and offsets never change outside a run.
- R5: If no sample was taken, each selected channel raises its fail flag (`failV`, `failI`) and keeps its old offset. The fail flags hold their value until the next accepted `start` clears them.
- R6: At the end of every run both filter coefficients are zero, whatever the selects or failures. While idle, `hpfLoad` loads `hpfVIn` and `hpfIIn` into them.
- R7: `done` is high for exactly one cycle, after all offset writes and coefficient clears. `busy` is high from the cycle after the accepted start through the `done` cycle, and a `start` while busy is ignored.
- R8: The sample count saturates at 2^(CNT_W-1). Flagged samples after that point are not added.
- R9: `sampleValid` while idle has no effect on the offsets, the flags or `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration run (pulse) |
| selV | input | 1 | Calibrate the voltage channel |
| selI | input | 1 | Calibrate the current channel |
| calCycles | input | CYC_W | Interval length in clock cycles |
| sampleValid | input | 1 | Both sample inputs carry a new sample |
| vSample | input | SAMPLE_W | Signed voltage sample |
| iSample | input | SAMPLE_W | Signed current sample |
| hpfLoad | input | 1 | Load the filter coefficients |
| hpfVIn | input | COEF_W | Voltage filter coefficient to load |
| hpfIIn | input | COEF_W | Current filter coefficient to load |
| vOffset | output | SAMPLE_W | Voltage offset register |
| iOffset | output | SAMPLE_W | Current offset register |
| hpfCoefV | output | COEF_W | Voltage filter coefficient |
| hpfCoefI | output | COEF_W | Current filter coefficient |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| failV | output | 1 | Voltage channel had no samples |
| failI | output | 1 | Current channel had no samples |

## Verification
The bench keeps 24-bit samples but builds the engine with CNT_W=4 and ACC_W=28, so the count saturates after only eight samples. This makes the saturation limit reachable within a twelve-cycle interval. Full-scale positive and negative samples then drive the sum to the largest magnitude the accumulator must hold. CYC_W=8 keeps intervals short, and the cases of a zero-length interval and an interval with no samples still lead to the failure path.

// File: rtl/ocal_pkg.sv
package ocal_pkg;

  typedef struct packed {
    logic clrAcc;
    logic accEn;
    logic divStart;
    logic divSelI;
    logic wrOff;
    logic clrCoef;
  } ocal_strobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ACCUM, S_POSTV, S_WAITV, S_POSTI, S_WAITI, S_FINISH, S_DONE
  } ocal_state_t;

endpackage

// File: rtl/ocal_ctrl.sv
module ocal_ctrl
  import ocal_pkg::*;
#(
  parameter int CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             selV,
  input  logic             selI,
  input  logic [CYC_W-1:0] calCycles,
  input  logic             divDone,
  input  logic             countZero,
  output ocal_strobe_t     strobe,
  output logic             busy,
  output logic             done,
  output logic             failV,
  output logic             failI
);

  ocal_state_t     state, stateNext;
  logic [CYC_W-1:0] cycLeft;
  logic            selVq, selIq;
  logic            cycActive;

  assign cycActive = (cycLeft != '0);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strobe.clrAcc = 1'b1;
          stateNext     = S_ACCUM;
        end
      end
      S_ACCUM: begin
        strobe.accEn = cycActive;
        if (cycLeft <= CYC_W'(1)) stateNext = S_POSTV;
      end
      S_POSTV: begin
        if (selVq && !countZero) begin
          strobe.divStart = 1'b1;
          stateNext       = S_WAITV;
        end else begin
          stateNext = S_POSTI;
        end
      end
      S_WAITV: begin
        if (divDone) begin
          strobe.wrOff = 1'b1;
          stateNext    = S_POSTI;
        end
      end
      S_POSTI: begin
        strobe.divSelI = 1'b1;
        if (selIq && !countZero) begin
          strobe.divStart = 1'b1;
          stateNext       = S_WAITI;
        end else begin
          stateNext = S_FINISH;
        end
      end
      S_WAITI: begin
        strobe.divSelI = 1'b1;
        if (divDone) begin
          strobe.wrOff = 1'b1;
          stateNext    = S_FINISH;
        end
      end
      S_FINISH: begin
        strobe.clrCoef = 1'b1;
        stateNext      = S_DONE;
      end
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cycLeft <= '0;
      selVq   <= 1'b0;
      selIq   <= 1'b0;
      failV   <= 1'b0;
      failI   <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && start) begin
        cycLeft <= calCycles;
        selVq   <= selV;
        selIq   <= selI;
        failV   <= 1'b0;
        failI   <= 1'b0;
      end else if (state == S_ACCUM && cycActive) begin
        cycLeft <= cycLeft - CYC_W'(1);
      end
      if (state == S_POSTV && selVq && countZero) failV <= 1'b1;
      if (state == S_POSTI && selIq && countZero) failI <= 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

endmodule

// File: rtl/ocal_dp.sv
module ocal_dp
  import ocal_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int ACC_W    = 48,
  parameter int CNT_W    = 25,
  parameter int COEF_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ocal_strobe_t        strobe,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] vSample,
  input  logic [SAMPLE_W-1:0] iSample,
  input  logic                hpfLoad,
  input  logic [COEF_W-1:0]   hpfVIn,
  input  logic [COEF_W-1:0]   hpfIIn,
  output logic                divDone,
  output logic                countZero,
  output logic [SAMPLE_W-1:0] vOffset,
  output logic [SAMPLE_W-1:0] iOffset,
  output logic [COEF_W-1:0]   hpfCoefV,
  output logic [COEF_W-1:0]   hpfCoefI
);

  localparam int NUM_CH = 2;
  localparam int EXT_W  = ACC_W - SAMPLE_W;
  localparam int IT_W   = $clog2(ACC_W + 1);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(1) << (CNT_W - 1);

  logic [NUM_CH-1:0][SAMPLE_W-1:0] chSample;
  logic [NUM_CH-1:0][ACC_W-1:0]    chSum;
  logic [CNT_W-1:0]                sampleCnt;
  logic                            takeSample;

  assign chSample   = {iSample, vSample};
  assign takeSample = strobe.accEn && sampleValid && (sampleCnt != MAX_CNT);
  assign countZero  = (sampleCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sampleCnt <= '0;
    else if (strobe.clrAcc)  sampleCnt <= '0;
    else if (takeSample)     sampleCnt <= sampleCnt + CNT_W'(1);
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_acc
    logic [ACC_W-1:0] extSample;
    assign extSample = {{EXT_W{chSample[ch][SAMPLE_W-1]}}, chSample[ch]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             chSum[ch] <= '0;
      else if (strobe.clrAcc) chSum[ch] <= '0;
      else if (takeSample)    chSum[ch] <= chSum[ch] + extSample;
    end
  end

  // shared restoring divider on magnitudes, sign applied afterwards
  logic [ACC_W-1:0] divSum, divMag, quoQ, quoSigned;
  logic [CNT_W-1:0] remQ, divisorQ;
  logic [CNT_W:0]   remShift, remDiff;
  logic [IT_W-1:0]  itQ;
  logic             negQ, divActive;

  assign divSum   = strobe.divSelI ? chSum[1] : chSum[0];
  assign divMag   = divSum[ACC_W-1] ? (~divSum + ACC_W'(1)) : divSum;
  assign remShift = {remQ, quoQ[ACC_W-1]};
  assign remDiff  = remShift - {1'b0, divisorQ};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quoQ      <= '0;
      remQ      <= '0;
      divisorQ  <= '0;
      itQ       <= '0;
      negQ      <= 1'b0;
      divActive <= 1'b0;
    end else if (strobe.divStart) begin
      quoQ      <= divMag;
      remQ      <= '0;
      divisorQ  <= sampleCnt;
      itQ       <= IT_W'(ACC_W);
      negQ      <= divSum[ACC_W-1];
      divActive <= 1'b1;
    end else if (itQ != '0) begin
      if (remShift >= {1'b0, divisorQ}) begin
        remQ <= remDiff[CNT_W-1:0];
        quoQ <= {quoQ[ACC_W-2:0], 1'b1};
      end else begin
        remQ <= remShift[CNT_W-1:0];
        quoQ <= {quoQ[ACC_W-2:0], 1'b0};
      end
      itQ <= itQ - IT_W'(1);
    end else if (strobe.wrOff) begin
      divActive <= 1'b0;
    end
  end

  assign divDone   = divActive && (itQ == '0);
  assign quoSigned = negQ ? (~quoQ + ACC_W'(1)) : quoQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vOffset <= '0;
      iOffset <= '0;
    end else if (strobe.wrOff) begin
      if (strobe.divSelI) iOffset <= quoSigned[SAMPLE_W-1:0];
      else                vOffset <= quoSigned[SAMPLE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpfCoefV <= '0;
      hpfCoefI <= '0;
    end else if (strobe.clrCoef) begin
      hpfCoefV <= '0;
      hpfCoefI <= '0;
    end else if (hpfLoad) begin
      hpfCoefV <= hpfVIn;
      hpfCoefI <= hpfIIn;
    end
  end

endmodule

// File: rtl/offset_cal_engine.sv
module offset_cal_engine
  import ocal_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 25,
  parameter int ACC_W    = SAMPLE_W + CNT_W - 1,
  parameter int CYC_W    = 32,
  parameter int COEF_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                selV,
  input  logic                selI,
  input  logic [CYC_W-1:0]    calCycles,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] vSample,
  input  logic [SAMPLE_W-1:0] iSample,
  input  logic                hpfLoad,
  input  logic [COEF_W-1:0]   hpfVIn,
  input  logic [COEF_W-1:0]   hpfIIn,
  output logic [SAMPLE_W-1:0] vOffset,
  output logic [SAMPLE_W-1:0] iOffset,
  output logic [COEF_W-1:0]   hpfCoefV,
  output logic [COEF_W-1:0]   hpfCoefI,
  output logic                busy,
  output logic                done,
  output logic                failV,
  output logic                failI
);

  ocal_strobe_t strobe;
  logic         divDone, countZero;

  ocal_ctrl #(.CYC_W(CYC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .selV(selV), .selI(selI),
    .calCycles(calCycles), .divDone(divDone), .countZero(countZero),
    .strobe(strobe), .busy(busy), .done(done), .failV(failV), .failI(failI)
  );

  ocal_dp #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .COEF_W(COEF_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sampleValid(sampleValid),
    .vSample(vSample), .iSample(iSample), .hpfLoad(hpfLoad),
    .hpfVIn(hpfVIn), .hpfIIn(hpfIIn), .divDone(divDone), .countZero(countZero),
    .vOffset(vOffset), .iOffset(iOffset), .hpfCoefV(hpfCoefV), .hpfCoefI(hpfCoefI)
  );

endmodule

// File: rtl/ocal_chk.sv
module ocal_chk #(
  parameter int SAMPLE_W = 24,
  parameter int COEF_W   = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                failV,
  input logic                failI,
  input logic [SAMPLE_W-1:0] vOffset,
  input logic [SAMPLE_W-1:0] iOffset,
  input logic [COEF_W-1:0]   hpfCoefV,
  input logic [COEF_W-1:0]   hpfCoefI
);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  assert_coef_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hpfCoefV == '0 && hpfCoefI == '0));

  assert_voff_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vOffset) |-> $past(busy));

  assert_ioff_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(iOffset) |-> $past(busy));

  assert_fail_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(failV) || !$stable(failI)) |-> ($past(busy) || $past(start)));

endmodule

bind offset_cal_engine ocal_chk #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) u_ocal_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .failV(failV), .failI(failI), .vOffset(vOffset), .iOffset(iOffset),
  .hpfCoefV(hpfCoefV), .hpfCoefI(hpfCoefI)
);

// File: tb/offset_cal_engine_bench.sv
module offset_cal_engine_bench;

  localparam int SAMPLE_W = 24;
  localparam int CNT_W    = 4;
  localparam int ACC_W    = 28;
  localparam int CYC_W    = 8;
  localparam int COEF_W   = 16;
  localparam int CAP      = 1 << (CNT_W - 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, selV, selI, sampleValid, hpfLoad;
  logic [CYC_W-1:0]    calCycles;
  logic [SAMPLE_W-1:0] vSample, iSample, vOffset, iOffset;
  logic [COEF_W-1:0]   hpfVIn, hpfIIn, hpfCoefV, hpfCoefI;
  logic busy, done, failV, failI;

  offset_cal_engine #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .ACC_W(ACC_W),
                      .CYC_W(CYC_W), .COEF_W(COEF_W)) u_offset_cal_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .selV(selV), .selI(selI),
    .calCycles(calCycles), .sampleValid(sampleValid), .vSample(vSample),
    .iSample(iSample), .hpfLoad(hpfLoad), .hpfVIn(hpfVIn), .hpfIIn(hpfIIn),
    .vOffset(vOffset), .iOffset(iOffset), .hpfCoefV(hpfCoefV), .hpfCoefI(hpfCoefI),
    .busy(busy), .done(done), .failV(failV), .failI(failI)
  );

  int checks = 0;
  int failures = 0;
  longint vs[32];
  longint is[32];
  bit     val[32];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint sx(input logic [SAMPLE_W-1:0] x);
    return longint'($signed(x));
  endfunction

  task automatic fillRandom(input int n, input bit sparse);
    for (int k = 0; k < n; k++) begin
      logic [SAMPLE_W-1:0] a, b;
      a = SAMPLE_W'($urandom);
      b = SAMPLE_W'($urandom);
      vs[k] = sx(a);
      is[k] = sx(b);
      val[k] = sparse ? bit'(k % 3 != 1) : 1'b1;
    end
  endtask

  task automatic fillConst(input int n, input longint v, input longint i, input bit vl);
    for (int k = 0; k < n; k++) begin
      vs[k] = v; is[k] = i; val[k] = vl;
    end
  endtask

  task automatic loadCoef(input logic [COEF_W-1:0] cv, input logic [COEF_W-1:0] ci);
    @(negedge clk);
    hpfLoad = 1'b1; hpfVIn = cv; hpfIIn = ci;
    @(negedge clk);
    hpfLoad = 1'b0;
    check(hpfCoefV == cv && hpfCoefI == ci, "R6", "coefficient load", longint'(hpfCoefV), longint'(cv));
  endtask

  // one complete run; expected values derived from the stimulus
  task automatic runCal(input bit sv, input bit si, input int n, input bit poke);
    longint sumV = 0, sumI = 0, expV, expI;
    int cnt = 0, w = 0;
    longint prevV = sx(vOffset), prevI = sx(iOffset);
    @(negedge clk);
    selV = sv; selI = si; calCycles = CYC_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", "busy after start", longint'(busy), 1);
    check(failV == 1'b0 && failI == 1'b0, "R5", "fail flags cleared by start",
          longint'({failV, failI}), 0);
    for (int k = 0; k < n; k++) begin
      sampleValid = val[k];
      vSample = SAMPLE_W'(vs[k]);
      iSample = SAMPLE_W'(is[k]);
      start = poke && (k == 1);
      selV = ~sv; selI = ~si;
      if (val[k] && cnt < CAP) begin
        sumV += vs[k]; sumI += is[k]; cnt++;
      end
      @(negedge clk);
    end
    sampleValid = 1'b0; start = 1'b0;
    while (!done && w < 400) begin
      @(negedge clk);
      w++;
    end
    check(done == 1'b1, "R7", "done seen", longint'(done), 1);
    expV = (sv && cnt > 0) ? sumV / cnt : prevV;
    expI = (si && cnt > 0) ? sumI / cnt : prevI;
    check(sx(vOffset) == expV, "R3", "voltage offset", sx(vOffset), expV);
    check(sx(iOffset) == expI, "R4", "current offset", sx(iOffset), expI);
    check(failV == (sv && cnt == 0), "R5", "failV", longint'(failV), longint'(sv && cnt == 0));
    check(failI == (si && cnt == 0), "R5", "failI", longint'(failI), longint'(si && cnt == 0));
    check(hpfCoefV == '0 && hpfCoefI == '0, "R6", "coefficients cleared",
          longint'({hpfCoefV, hpfCoefI}), 0);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7", "done single cycle then idle",
          longint'({done, busy}), 0);
  endtask

  task automatic testReset();
    check(vOffset == '0 && iOffset == '0, "R1", "offsets at reset", sx(vOffset), 0);
    check(hpfCoefV == '0 && hpfCoefI == '0, "R1", "coefs at reset", longint'(hpfCoefV), 0);
    check({busy, done, failV, failI} == 4'b0, "R1", "flags at reset",
          longint'({busy, done, failV, failI}), 0);
  endtask

  task automatic testBoth();     // R2 R3: both channels, dense samples
    loadCoef(16'h1234, 16'h0F0F);
    fillRandom(6, 1'b0);
    runCal(1'b1, 1'b1, 6, 1'b0);
  endtask

  task automatic testVOnlyRound(); // R3 R4: negative non-divisible sum, I untouched
    loadCoef(16'h0001, 16'h8000);
    vs[0] = -7; vs[1] = -3; vs[2] = 0; vs[3] = -1; vs[4] = 2;
    for (int k = 0; k < 5; k++) begin is[k] = 1000; val[k] = 1'b1; end
    runCal(1'b1, 1'b0, 5, 1'b0);
    check(sx(vOffset) == -1, "R3", "truncation toward zero", sx(vOffset), -1);
  endtask

  task automatic testIOnlySparse(); // R2 R4: gaps in sampleValid
    fillRandom(9, 1'b1);
    runCal(1'b0, 1'b1, 9, 1'b0);
  endtask

  task automatic testNoSamples(); // R5: interval without valid samples
    loadCoef(16'h00AA, 16'h5500);
    fillConst(4, 5, 5, 1'b0);
    runCal(1'b1, 1'b1, 4, 1'b0);
    runCal(1'b1, 1'b0, 0, 1'b0);
  endtask

  task automatic testCap(); // R8: count saturates at CAP samples
    for (int k = 0; k < 12; k++) begin
      vs[k] = (k < CAP) ? 100 : -5000000; is[k] = (k < CAP) ? -40 : 7000000; val[k] = 1'b1;
    end
    runCal(1'b1, 1'b1, 12, 1'b0);
    check(sx(vOffset) == 100 && sx(iOffset) == -40, "R8", "samples beyond cap ignored",
          sx(vOffset), 100);
  endtask

  task automatic testExtremes(); // R3 R8: full-scale sums
    fillConst(CAP, -(longint'(1) << (SAMPLE_W - 1)), (longint'(1) << (SAMPLE_W - 1)) - 1, 1'b1);
    runCal(1'b1, 1'b1, CAP, 1'b0);
  endtask

  task automatic testBusyStart(); // R7: start during a run ignored
    int pulses = 0;
    fillRandom(5, 1'b0);
    runCal(1'b1, 1'b0, 5, 1'b1);
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    check(pulses == 0 && busy == 1'b0, "R7", "no second run from busy start",
          longint'(pulses), 0);
  endtask

  task automatic testIdleSamples(); // R9: samples while idle do nothing
    longint pv = sx(vOffset), pi = sx(iOffset);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      sampleValid = 1'b1; vSample = SAMPLE_W'(12345 * (k + 1)); iSample = SAMPLE_W'(-777);
    end
    @(negedge clk);
    sampleValid = 1'b0;
    check(sx(vOffset) == pv && sx(iOffset) == pi, "R9", "offsets unchanged while idle",
          sx(vOffset), pv);
    check(busy == 1'b0 && done == 1'b0, "R9", "idle stays idle", longint'({busy, done}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; selV = 1'b0; selI = 1'b0; calCycles = '0;
    sampleValid = 1'b0; vSample = '0; iSample = '0; hpfLoad = 1'b0;
    hpfVIn = '0; hpfIIn = '0;
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testBoth();
    testVOnlyRound();
    testIOnlySparse();
    testNoSamples();
    testCap();
    testExtremes();
    testBusyStart();
    testIdleSamples();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule